// File: doc/BRIEF.md
# Twelve-Hour Alarm Clock Core

This block keeps the time of day in twelve-hour form: hours, minutes, seconds and a half-day flag. Every rising edge of its clock is one second. Wider logic supplies that clock as a one-second tick. A time-load strobe presets all four time fields on the next edge. A separate alarm-load strobe stores an alarm time made of hours, minutes and half-day flag. The alarm time has no seconds field.

When the alarm is enabled and the running time reaches the stored alarm time with seconds at zero, the ring output rises. It stays high for a programmable number of seconds. Dropping the enable silences the ring at once and discards the rest of the countdown. A time-invalid indicator is high from reset until the first time load, so a display can blink the clock until the user sets it.

Top module: `alarm_clock12`

## Requirements
- R1: While reset is asserted and right after it, the time reads 12:00:00 with pm_o = 0 (AM), time_invalid is 1 and ring is 0.
- R2: A high ld_time at a clock edge loads set_hr, set_min, set_sec and set_pm into the outputs at that edge. The load wins over normal counting.
- R3: Without a load, seconds advance by one per edge. Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours run 12, 1, 2, ..., 11, 12.
- R4: pm_o (0 = AM, 1 = PM) changes only on the step from 11:59:59 to 12:00:00. It inverts on that step.
- R5: A high ld_alarm at an edge stores alm_hr, alm_min and alm_pm. A match needs the hours, the minutes and the half-day flag all equal to the stored values, with seconds equal to 0.
- R6: Suppose that in some cycle alm_en is high, alm_len is N > 0 and the time matches. Then ring rises at the next edge and stays high for exactly N cycles. With N = 0 the ring never rises.
- R7: While alm_en is low, ring is 0 in the same cycle and no match can trigger. Any remaining countdown is cleared, so raising alm_en again does not resume it.
- R8: time_invalid stays 1 from reset until the first edge with ld_time high. After that it stays 0 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | One-second tick clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_time | input | 1 | Preset the running time from set_* |
| set_hr | input | 4 | Hours to load, 1..12 |
| set_min | input | 6 | Minutes to load, 0..59 |
| set_sec | input | 6 | Seconds to load, 0..59 |
| set_pm | input | 1 | Half-day flag to load, 1 = PM |
| ld_alarm | input | 1 | Store alarm time from alm_* |
| alm_hr | input | 4 | Alarm hours, 1..12 |
| alm_min | input | 6 | Alarm minutes, 0..59 |
| alm_pm | input | 1 | Alarm half-day flag, 1 = PM |
| alm_en | input | 1 | Alarm enable |
| alm_len | input | DUR_W (8) | Ring length in seconds |
| hr_o | output | 4 | Current hours |
| min_o | output | 6 | Current minutes |
| sec_o | output | 6 | Current seconds |
| pm_o | output | 1 | Current half-day flag |
| time_invalid | output | 1 | High until the time is first loaded |
| ring | output | 1 | Alarm sounding |

## Verification
A wrong carry or wrap in the time counters shows on the time outputs one edge after the load or tick that exercises it. The bench therefore loads times placed just before each wrap point and checks the time one tick later. A faulty alarm register or compare shows up as a missing, early or extra ring one edge after the matching second. A countdown that is off by one shows up as the ring edge that falls one cycle away from the expected position. A stuck invalid flag is visible the cycle after the first load.

// File: rtl/clk12_pkg.sv
package clk12_pkg;
  localparam int HR_W = 4;
  localparam int MS_W = 6;

  localparam logic [HR_W-1:0] HR_TOP = HR_W'(12);
  localparam logic [HR_W-1:0] HR_PRE = HR_W'(11);
  localparam logic [HR_W-1:0] HR_ONE = HR_W'(1);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(59);
  localparam logic [MS_W-1:0] MS_ONE = MS_W'(1);

  typedef struct packed {
    logic [HR_W-1:0] hr;
    logic [MS_W-1:0] min;
    logic [MS_W-1:0] sec;
    logic            pm;
  } tod_t;

  typedef struct packed {
    logic [HR_W-1:0] hr;
    logic [MS_W-1:0] min;
    logic            pm;
  } alm_t;
endpackage

// File: rtl/clk12_time_keeper.sv
module clk12_time_keeper
  import clk12_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  tod_t ld_val,
  output tod_t now,
  output logic invalid
);
  tod_t now_d;
  logic sec_wrap, min_wrap;
  logic seen_q, seen_d, seen_we;

  always_comb begin
    sec_wrap = (now.sec == MS_LAST);
    min_wrap = sec_wrap && (now.min == MS_LAST);
    now_d    = now;
    if (ld) begin
      now_d = ld_val;
    end else begin
      now_d.sec = sec_wrap ? '0 : now.sec + MS_ONE;
      if (sec_wrap) now_d.min = (now.min == MS_LAST) ? '0 : now.min + MS_ONE;
      if (min_wrap) begin
        now_d.hr = (now.hr == HR_TOP) ? HR_ONE : now.hr + HR_ONE;
        if (now.hr == HR_PRE) now_d.pm = ~now.pm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now.hr  <= HR_TOP;
      now.min <= '0;
      now.sec <= '0;
      now.pm  <= 1'b0;
    end else begin
      now <= now_d;
    end
  end

  assign seen_we = ld && !seen_q;
  assign seen_d  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_q <= 1'b0;
    else if (seen_we) seen_q <= seen_d;
  end

  assign invalid = !seen_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (now == $past(ld_val)));

  p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ld) |-> (now.sec <= MS_LAST && now.min <= MS_LAST &&
                    now.hr >= HR_ONE && now.hr <= HR_TOP));

  p_pm_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ld) && (now.pm != $past(now.pm))) |->
      (now.hr == HR_TOP && now.min == '0 && now.sec == '0));

  p_invalid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !invalid |=> !invalid);
endmodule

// File: rtl/clk12_alarm_unit.sv
module clk12_alarm_unit
  import clk12_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  alm_t             ld_val,
  input  logic             en,
  input  logic [DUR_W-1:0] len,
  input  tod_t             now,
  output logic             ring
);
  localparam logic [DUR_W-1:0] DUR_ONE = DUR_W'(1);

  alm_t             alm_q;
  logic             hit;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q.hr  <= HR_TOP;
      alm_q.min <= '0;
      alm_q.pm  <= 1'b0;
    end else if (ld) begin
      alm_q <= ld_val;
    end
  end

  always_comb begin
    hit = en && (now.sec == '0) && (now.hr == alm_q.hr) &&
          (now.min == alm_q.min) && (now.pm == alm_q.pm);
    cnt_we = !en || hit || (cnt_q != '0);
    if (!en)      cnt_d = '0;
    else if (hit) cnt_d = len;
    else          cnt_d = cnt_q - DUR_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign ring = en && (cnt_q != '0);

  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && len != '0) |=> (ring || !en));

  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hit && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_drop_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/alarm_clock12.sv
module alarm_clock12
  import clk12_pkg::*;
#(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_time,
  input  logic [3:0]       set_hr,
  input  logic [5:0]       set_min,
  input  logic [5:0]       set_sec,
  input  logic             set_pm,
  input  logic             ld_alarm,
  input  logic [3:0]       alm_hr,
  input  logic [5:0]       alm_min,
  input  logic             alm_pm,
  input  logic             alm_en,
  input  logic [DUR_W-1:0] alm_len,
  output logic [3:0]       hr_o,
  output logic [5:0]       min_o,
  output logic [5:0]       sec_o,
  output logic             pm_o,
  output logic             time_invalid,
  output logic             ring
);
  tod_t tod_ld, tod_now;
  alm_t alm_ld;

  assign tod_ld = '{hr: set_hr, min: set_min, sec: set_sec, pm: set_pm};
  assign alm_ld = '{hr: alm_hr, min: alm_min, pm: alm_pm};

  clk12_time_keeper u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld      (ld_time),
    .ld_val  (tod_ld),
    .now     (tod_now),
    .invalid (time_invalid)
  );

  clk12_alarm_unit #(.DUR_W(DUR_W)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ld_alarm),
    .ld_val (alm_ld),
    .en     (alm_en),
    .len    (alm_len),
    .now    (tod_now),
    .ring   (ring)
  );

  assign hr_o  = tod_now.hr;
  assign min_o = tod_now.min;
  assign sec_o = tod_now.sec;
  assign pm_o  = tod_now.pm;

  p_invalid_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(time_invalid) |-> $past(ld_time));
endmodule

// File: tb/sim_alarm_clock12.sv
`timescale 1ns/1ps
module sim_alarm_clock12;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_time, set_pm, ld_alarm, alm_pm, alm_en;
  logic [3:0] set_hr, alm_hr;
  logic [5:0] set_min, set_sec, alm_min;
  logic [7:0] alm_len;
  logic [3:0] hr_o;
  logic [5:0] min_o, sec_o;
  logic       pm_o, time_invalid, ring;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alarm_clock12 u0 (
    .clk(clk), .rst_n(rst_n), .ld_time(ld_time), .set_hr(set_hr),
    .set_min(set_min), .set_sec(set_sec), .set_pm(set_pm),
    .ld_alarm(ld_alarm), .alm_hr(alm_hr), .alm_min(alm_min),
    .alm_pm(alm_pm), .alm_en(alm_en), .alm_len(alm_len),
    .hr_o(hr_o), .min_o(min_o), .sec_o(sec_o), .pm_o(pm_o),
    .time_invalid(time_invalid), .ring(ring)
  );

  // {hr,min,sec,pm} loaded, then {hr,min,sec,pm} one tick later
  localparam logic [33:0] VEC [8] = '{
    {4'd1,  6'd7,  6'd9,  1'b0, 4'd1,  6'd7,  6'd10, 1'b0},
    {4'd11, 6'd59, 6'd59, 1'b0, 4'd12, 6'd0,  6'd0,  1'b1},
    {4'd11, 6'd59, 6'd59, 1'b1, 4'd12, 6'd0,  6'd0,  1'b0},
    {4'd12, 6'd59, 6'd59, 1'b0, 4'd1,  6'd0,  6'd0,  1'b0},
    {4'd12, 6'd59, 6'd59, 1'b1, 4'd1,  6'd0,  6'd0,  1'b1},
    {4'd5,  6'd30, 6'd59, 1'b1, 4'd5,  6'd31, 6'd0,  1'b1},
    {4'd10, 6'd59, 6'd59, 1'b0, 4'd11, 6'd0,  6'd0,  1'b0},
    {4'd12, 6'd0,  6'd59, 1'b1, 4'd12, 6'd1,  6'd0,  1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] now_vec();
    return {hr_o, min_o, sec_o, pm_o};
  endfunction

  task automatic load_time(input logic [3:0] h, input logic [5:0] m,
                           input logic [5:0] s, input logic p);
    set_hr = h; set_min = m; set_sec = s; set_pm = p; ld_time = 1'b1;
    tick();
    ld_time = 1'b0;
  endtask

  task automatic load_alarm(input logic [3:0] h, input logic [5:0] m, input logic p);
    alm_hr = h; alm_min = m; alm_pm = p; ld_alarm = 1'b1;
    tick();
    ld_alarm = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ld_time = 1'b0; ld_alarm = 1'b0; alm_en = 1'b0;
    set_hr = 4'd0; set_min = 6'd0; set_sec = 6'd0; set_pm = 1'b0;
    alm_hr = 4'd0; alm_min = 6'd0; alm_pm = 1'b0; alm_len = 8'd10;
    repeat (3) tick();
    chk(now_vec() == {4'd12, 6'd0, 6'd0, 1'b0}, "R1 time", int'(now_vec()),
        int'({4'd12, 6'd0, 6'd0, 1'b0}));
    chk(time_invalid == 1'b1, "R1 invalid", int'(time_invalid), 1);
    chk(ring == 1'b0, "R1 ring", int'(ring), 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(now_vec() == {4'd12, 6'd0, 6'd3, 1'b0}, "R3 free count", int'(now_vec()),
        int'({4'd12, 6'd0, 6'd3, 1'b0}));
    chk(time_invalid == 1'b1, "R8 invalid before load", int'(time_invalid), 1);

    // vector table: load priority, wraps and half-day step
    foreach (VEC[i]) begin
      load_time(VEC[i][33:30], VEC[i][29:24], VEC[i][23:18], VEC[i][17]);
      chk(now_vec() == VEC[i][33:17], "R2 load", int'(now_vec()), int'(VEC[i][33:17]));
      tick();
      chk(now_vec() == VEC[i][16:0], "R3/R4 step", int'(now_vec()), int'(VEC[i][16:0]));
    end
    chk(time_invalid == 1'b0, "R8 invalid after load", int'(time_invalid), 0);

    // R6: alarm 4:22 AM, length 10
    load_alarm(4'd4, 6'd22, 1'b0);
    load_time(4'd4, 6'd21, 6'd58, 1'b0);
    alm_en = 1'b1;
    tick();
    tick();
    chk(ring == 1'b0, "R6 not before match edge", int'(ring), 0);
    tick();
    for (int k = 0; k < 10; k++) begin
      chk(ring == 1'b1, "R6 ring held", int'(ring), 1);
      tick();
    end
    chk(ring == 1'b0, "R6 ring ends after length", int'(ring), 0);

    // R5: half-day mismatch
    alm_en = 1'b0;
    load_alarm(4'd4, 6'd22, 1'b1);
    load_time(4'd4, 6'd21, 6'd59, 1'b0);
    alm_en = 1'b1;
    tick(); tick();
    chk(ring == 1'b0, "R5 pm mismatch", int'(ring), 0);

    // R5: seconds must be zero
    alm_en = 1'b0;
    load_alarm(4'd4, 6'd22, 1'b0);
    load_time(4'd4, 6'd22, 6'd1, 1'b0);
    alm_en = 1'b1;
    tick(); tick();
    chk(ring == 1'b0, "R5 seconds not zero", int'(ring), 0);

    // R7: enable dropped during ring
    alm_en = 1'b0;
    load_time(4'd4, 6'd21, 6'd59, 1'b0);
    alm_en = 1'b1;
    tick(); tick();
    chk(ring == 1'b1, "R7 ring active", int'(ring), 1);
    tick();
    alm_en = 1'b0;
    #1;
    chk(ring == 1'b0, "R7 immediate clear", int'(ring), 0);
    tick();
    alm_en = 1'b1;
    #1;
    chk(ring == 1'b0, "R7 countdown discarded", int'(ring), 0);
    tick();
    chk(ring == 1'b0, "R7 stays off", int'(ring), 0);

    // R7: disabled at match second
    alm_en = 1'b0;
    load_time(4'd4, 6'd21, 6'd59, 1'b0);
    tick(); tick();
    chk(ring == 1'b0, "R7 no trigger when off", int'(ring), 0);
    alm_en = 1'b1;
    tick();
    chk(ring == 1'b0, "R7 late enable no ring", int'(ring), 0);

    // R6: zero length
    alm_en = 1'b0;
    alm_len = 8'd0;
    load_time(4'd4, 6'd21, 6'd59, 1'b0);
    alm_en = 1'b1;
    tick(); tick();
    chk(ring == 1'b0, "R6 zero length", int'(ring), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule